// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits behind the host write port of a parallel flash device. It watches every bus write (strobe, address and data), recognises the multi-cycle unlock-and-command sequences the host issues, and keeps track of the operating mode of the device. The possible modes are array read, identifier read (autoselect), a shortened program mode (unlock bypass), query (CFI), a secure region overlay and a suspended erase. The rest of the device reads the mode flags to decide what a read returns and which array operations may start.

When a sequence requests work from the array (program, chip erase, sector erase, erase suspend or erase resume), the block raises `op_valid` for exactly one clock cycle, one cycle after the completing write. It presents the operation code, the address and the data of that write with the pulse, and for a sector erase it also updates the latched sector number. The pulse has no ready input and cannot be held back: the array controller must take the request in the cycle it appears. Bus writes are never stalled either, and each clocked cycle with `wr_en` high counts as one bus write. The array controller drives `busy` while an erase is running, and the block then ignores every write except the suspend byte.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset only `mode_read` is high among the mode flags, and `op_valid` is low.
- R2: An unlock prefix is a write of AAh with address bits [11:0] = 555h, followed by a write of 55h with bits [11:0] = 2AAh. Address bits above bit 11 are ignored. A wrong address or byte in either prefix write drops the sequence and leaves the mode flags unchanged.
- R3: A program is the prefix, then command A0h, then one write. One cycle after that write, `op_valid` is high for one cycle with `op_kind` = 1, and `op_addr` and `op_data` equal that write's address and data.
- R4: A write of F0h outside a program data cycle ends any partial sequence. It returns autoselect or query mode to array read, keeps an erase suspend in force and leaves unlock bypass in place. In a program data cycle, F0h is programmed as data.
- R5: The prefix then 90h enters autoselect mode. In autoselect mode, only F0h and 98h have any effect.
- R6: A single write of 98h enters query mode from array read (when not suspended) or from autoselect. In query mode, only F0h has any effect.
- R7: The prefix, 80h, the prefix again, then 10h requests a chip erase (`op_kind` = 2). The same sequence ending in 30h requests a sector erase (`op_kind` = 3), and `sector` takes address bits [21:16] of that last write.
- R8: The prefix then 20h enters unlock bypass mode. In that mode, A0h followed by one write requests a program (`op_kind` = 1), and 90h followed by 00h returns to array read. All other writes are ignored.
- R9: The prefix then 88h sets `mode_secure`. The prefix, 90h, then 00h clears it.
- R10: While `busy` is high, every write is ignored except B0h. B0h is accepted only if the most recent erase was a sector erase and no suspend is active. It then requests a suspend (`op_kind` = 4) and sets `mode_susp`, which also clears `mode_read`.
- R11: While suspended and not busy, a single write of 30h requests a resume (`op_kind` = 5), clears `mode_susp` and restores `mode_read`. A 30h write when not suspended does nothing. While suspended, the erase command 80h is refused, but programs are still accepted.
- R12: Any byte other than A0h, 90h, 80h, 88h or 20h in the command position drops the sequence and leaves the mode flags unchanged.
- R13: Mode flags and `op_valid` change only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data; the low 8 bits carry command bytes |
| busy | input | 1 | Erase in progress, driven by the array controller |
| mode_read | output | 1 | Array read mode, not suspended |
| mode_autosel | output | 1 | Autoselect (identifier read) mode |
| mode_bypass | output | 1 | Unlock bypass mode |
| mode_cfi | output | 1 | Query mode |
| mode_susp | output | 1 | Erase suspended |
| mode_secure | output | 1 | Secure region overlay active |
| op_valid | output | 1 | One-cycle array operation request |
| op_kind | output | 3 | 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Data of the completing write |
| sector | output | SECT_W | Sector number of the last sector erase |

## Verification
The bench builds the block with its default values: a 22-bit address, 8-bit data, a 6-bit sector field and a 12-bit unlock compare. With these values it can set address bits 21 to 12 to arbitrary values during the unlock cycles, which shows those bits are ignored. It can also place a sector erase at address 2A0000h and check that the sector number comes from the top six address bits. The 8-bit data path makes every command byte, including F0h as programmed data, directly reachable.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] B_UNLK1  = 8'hAA;
  localparam logic [CMD_W-1:0] B_UNLK2  = 8'h55;
  localparam logic [CMD_W-1:0] B_PROG   = 8'hA0;
  localparam logic [CMD_W-1:0] B_ASEL   = 8'h90;
  localparam logic [CMD_W-1:0] B_ERASE  = 8'h80;
  localparam logic [CMD_W-1:0] B_SECIN  = 8'h88;
  localparam logic [CMD_W-1:0] B_BYPIN  = 8'h20;
  localparam logic [CMD_W-1:0] B_RESET  = 8'hF0;
  localparam logic [CMD_W-1:0] B_CHIP   = 8'h10;
  localparam logic [CMD_W-1:0] B_SECT   = 8'h30;
  localparam logic [CMD_W-1:0] B_SUSP   = 8'hB0;
  localparam logic [CMD_W-1:0] B_QUERY  = 8'h98;
  localparam logic [CMD_W-1:0] B_ZERO   = 8'h00;

  typedef enum logic [1:0] {
    BASE_READ = 2'd0,
    BASE_ASEL = 2'd1,
    BASE_BYP  = 2'd2,
    BASE_CFI  = 2'd3
  } base_e;

  typedef enum logic [3:0] {
    EV_NONE, EV_RST, EV_ASEL, EV_CFI, EV_SECIN, EV_SECOUT,
    EV_BYPIN, EV_BYPOUT, EV_PROG, EV_CHIP, EV_SECT, EV_SUSP, EV_RESUME
  } event_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_CHIP   = 3'd2,
    OP_SECT   = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5
  } op_e;
endpackage

// File: rtl/fcd_unlock_match.sv
module fcd_unlock_match #(
  parameter int UNLK_W = 12,
  parameter int DATA_W = 8,
  parameter logic [UNLK_W-1:0] ADDR_PAT = '0,
  parameter logic [7:0] DATA_PAT = 8'h00
) (
  input  logic [UNLK_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] data,
  output logic              hit
);
  assign hit = (addr_lo == ADDR_PAT) && (data[7:0] == DATA_PAT);
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8,
  parameter int UNLK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  base_e             base,
  input  logic              susp,
  input  logic              secure,
  input  logic              sect_run,
  output event_e            ev
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_CMD, ST_PGM, ST_E1, ST_E2, ST_E3,
    ST_BPGM, ST_BRST, ST_SX
  } st_e;

  st_e st, st_nxt;
  logic [1:0] hit;
  logic [CMD_W-1:0] cb;

  assign cb = wr_data[CMD_W-1:0];

  // hit[0]: first unlock write, hit[1]: second unlock write
  for (genvar g = 0; g < 2; g++) begin : g_unlk
    fcd_unlock_match #(
      .UNLK_W  (UNLK_W),
      .DATA_W  (DATA_W),
      .ADDR_PAT((g == 0) ? UNLK_W'(12'h555) : UNLK_W'(12'h2AA)),
      .DATA_PAT((g == 0) ? B_UNLK1 : B_UNLK2)
    ) i_match (
      .addr_lo(wr_addr[UNLK_W-1:0]),
      .data   (wr_data),
      .hit    (hit[g])
    );
  end

  always_comb begin
    st_nxt = st;
    ev     = EV_NONE;
    if (wr_en) begin
      if (busy) begin
        if (cb == B_SUSP && sect_run && !susp) begin
          ev     = EV_SUSP;
          st_nxt = ST_IDLE;
        end
      end else if (st != ST_PGM && st != ST_BPGM && cb == B_RESET) begin
        ev     = EV_RST;
        st_nxt = ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: begin
            unique case (base)
              BASE_CFI: ;
              BASE_ASEL: if (cb == B_QUERY) ev = EV_CFI;
              BASE_BYP: begin
                if (cb == B_PROG)      st_nxt = ST_BPGM;
                else if (cb == B_ASEL) st_nxt = ST_BRST;
              end
              default: begin
                if (hit[0])                      st_nxt = ST_U1;
                else if (cb == B_QUERY && !susp) ev = EV_CFI;
                else if (cb == B_SECT && susp)   ev = EV_RESUME;
              end
            endcase
          end
          ST_U1:  st_nxt = hit[1] ? ST_CMD : ST_IDLE;
          ST_CMD: begin
            st_nxt = ST_IDLE;
            if (cb == B_PROG)                          st_nxt = ST_PGM;
            else if (cb == B_ASEL && secure)           st_nxt = ST_SX;
            else if (cb == B_ASEL)                     ev = EV_ASEL;
            else if (cb == B_ERASE && !susp)           st_nxt = ST_E1;
            else if (cb == B_SECIN && !susp && !secure) ev = EV_SECIN;
            else if (cb == B_BYPIN && !susp && !secure) ev = EV_BYPIN;
          end
          ST_PGM, ST_BPGM: begin
            ev     = EV_PROG;
            st_nxt = ST_IDLE;
          end
          ST_E1: st_nxt = hit[0] ? ST_E2 : ST_IDLE;
          ST_E2: st_nxt = hit[1] ? ST_E3 : ST_IDLE;
          ST_E3: begin
            st_nxt = ST_IDLE;
            if (cb == B_CHIP)      ev = EV_CHIP;
            else if (cb == B_SECT) ev = EV_SECT;
          end
          ST_BRST: begin
            st_nxt = ST_IDLE;
            if (cb == B_ZERO) ev = EV_BYPOUT;
          end
          ST_SX: begin
            st_nxt = ST_IDLE;
            if (cb == B_ZERO) ev = EV_SECOUT;
          end
          default: st_nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  // R4
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && cb == B_RESET && st != ST_PGM && st != ST_BPGM)
      |=> st == ST_IDLE);

  // R2
  unlock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && st == ST_U1 && !hit[1]) |=> st == ST_IDLE);
endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
  import fcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  event_e ev,
  output base_e  base,
  output logic   susp,
  output logic   secure,
  output logic   sect_run
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base     <= BASE_READ;
      susp     <= 1'b0;
      secure   <= 1'b0;
      sect_run <= 1'b0;
    end else begin
      unique case (ev)
        EV_RST:    if (base != BASE_BYP) base <= BASE_READ;
        EV_ASEL:   base <= BASE_ASEL;
        EV_CFI:    base <= BASE_CFI;
        EV_BYPIN:  base <= BASE_BYP;
        EV_BYPOUT: base <= BASE_READ;
        EV_SECIN:  secure <= 1'b1;
        EV_SECOUT: secure <= 1'b0;
        EV_SECT:   sect_run <= 1'b1;
        EV_CHIP:   sect_run <= 1'b0;
        EV_SUSP:   susp <= 1'b1;
        EV_RESUME: begin
          susp <= 1'b0;
          base <= BASE_READ;
        end
        default: ;
      endcase
    end
  end

  // R5
  asel_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base == BASE_ASEL && $past(base) != BASE_ASEL) |-> $past(ev) == EV_ASEL);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8,
  parameter int SECT_W = 6,
  parameter int UNLK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              mode_read,
  output logic              mode_autosel,
  output logic              mode_bypass,
  output logic              mode_cfi,
  output logic              mode_susp,
  output logic              mode_secure,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [SECT_W-1:0] sector
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  event_e ev;
  base_e  base;
  logic   susp, secure, sect_run;
  op_e    kind_nxt;

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLK_W(UNLK_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .base(base), .susp(susp),
    .secure(secure), .sect_run(sect_run), .ev(ev)
  );

  fcd_mode i_mode (
    .clk(clk), .rst_n(rst_n), .ev(ev), .base(base), .susp(susp),
    .secure(secure), .sect_run(sect_run)
  );

  assign mode_read    = (base == BASE_READ) && !susp;
  assign mode_autosel = (base == BASE_ASEL);
  assign mode_bypass  = (base == BASE_BYP);
  assign mode_cfi     = (base == BASE_CFI);
  assign mode_susp    = susp;
  assign mode_secure  = secure;

  always_comb begin
    unique case (ev)
      EV_PROG:   kind_nxt = OP_PROG;
      EV_CHIP:   kind_nxt = OP_CHIP;
      EV_SECT:   kind_nxt = OP_SECT;
      EV_SUSP:   kind_nxt = OP_SUSP;
      EV_RESUME: kind_nxt = OP_RESUME;
      default:   kind_nxt = OP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_kind  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
      sector   <= '0;
    end else begin
      op_valid <= (kind_nxt != OP_NONE);
      if (kind_nxt != OP_NONE) begin
        op_kind <= kind_nxt;
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
      if (kind_nxt == OP_SECT) sector <= wr_addr[ADDR_W-1:SECT_LSB];
    end
  end

  // R13
  op_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_en));

  // R13
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable({mode_read, mode_autosel, mode_bypass,
                               mode_cfi, mode_susp, mode_secure}));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && wr_data[7:0] != B_SUSP) |=> !op_valid);

  // R10
  susp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_susp) |-> $past(busy && wr_en));

  // R7
  sect_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_SECT) |-> sector == $past(wr_addr[ADDR_W-1:SECT_LSB]));
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic mode_read, mode_autosel, mode_bypass, mode_cfi, mode_susp, mode_secure;
  logic        op_valid;
  logic [2:0]  op_kind;
  logic [21:0] op_addr;
  logic [7:0]  op_data;
  logic [5:0]  sector;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // flag word {secure, susp, cfi, bypass, autosel, read}
  localparam logic [5:0] F_READ = 6'b000001;
  localparam logic [5:0] F_ASEL = 6'b000010;
  localparam logic [5:0] F_BYP  = 6'b000100;
  localparam logic [5:0] F_CFI  = 6'b001000;
  localparam logic [5:0] F_SUSP = 6'b010000;
  localparam logic [5:0] F_SEC  = 6'b100000;

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .mode_read(mode_read),
    .mode_autosel(mode_autosel), .mode_bypass(mode_bypass),
    .mode_cfi(mode_cfi), .mode_susp(mode_susp), .mode_secure(mode_secure),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .sector(sector)
  );

  function automatic logic [5:0] flags();
    return {mode_secure, mode_susp, mode_cfi, mode_bypass, mode_autosel, mode_read};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus write; returns at the negedge where its result is visible
  task automatic wr(input logic [21:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prefix(input logic [9:0] hi);
    wr({hi, 12'h555}, 8'hAA);
    wr({hi, 12'h2AA}, 8'h55);
  endtask

  task automatic expect_op(input string req, input logic [2:0] k,
                           input logic [21:0] a, input logic [7:0] d);
    chk({req, " op_valid"}, op_valid, 1);
    chk({req, " op_kind"}, op_kind, k);
    chk({req, " op_addr"}, op_addr, a);
    chk({req, " op_data"}, op_data, d);
  endtask

  task automatic t_reset();
    chk("R1 flags", flags(), F_READ);
    chk("R1 op_valid", op_valid, 0);
  endtask

  task automatic t_unlock();
    // wrong second address
    wr(22'h000555, 8'hAA); wr(22'h0002AB, 8'h55); wr(22'h0, 8'hA0); wr(22'h100, 8'h12);
    chk("R2 bad addr no op", op_valid, 0);
    chk("R2 bad addr flags", flags(), F_READ);
    // wrong second byte
    wr(22'h000555, 8'hAA); wr(22'h0002AA, 8'h54); wr(22'h0, 8'hA0); wr(22'h100, 8'h12);
    chk("R2 bad data no op", op_valid, 0);
    // high address bits set on unlock cycles are ignored
    prefix(10'h3FF); wr(22'h3AB000, 8'hA0); wr(22'h012345, 8'h5A);
    expect_op("R2 R3 program", 3'd1, 22'h012345, 8'h5A);
    @(negedge clk);
    chk("R3 single cycle pulse", op_valid, 0);
  endtask

  task automatic t_reset_cmd();
    prefix(10'h0); wr(22'h0, 8'hF0); wr(22'h0, 8'hA0); wr(22'h200, 8'h77);
    chk("R4 abort partial", op_valid, 0);
    prefix(10'h0); wr(22'h0, 8'hA0); wr(22'h000321, 8'hF0);
    expect_op("R4 F0 as data", 3'd1, 22'h000321, 8'hF0);
  endtask

  task automatic t_asel_cfi();
    prefix(10'h1); wr(22'h555, 8'h90);
    chk("R5 autoselect", flags(), F_ASEL);
    prefix(10'h0); wr(22'h0, 8'hA0); wr(22'h44, 8'h33);
    chk("R5 program ignored", op_valid, 0);
    chk("R5 still autoselect", flags(), F_ASEL);
    wr(22'h55, 8'h98);
    chk("R6 query from autoselect", flags(), F_CFI);
    prefix(10'h0); wr(22'h555, 8'h90);
    chk("R6 query ignores others", flags(), F_CFI);
    wr(22'h0, 8'hF0);
    chk("R4 query to read", flags(), F_READ);
    wr(22'h55, 8'h98);
    chk("R6 query from read", flags(), F_CFI);
    wr(22'h0, 8'hF0);
    chk("R4 back to read", flags(), F_READ);
  endtask

  task automatic t_unknown();
    prefix(10'h0); wr(22'h555, 8'h77);
    chk("R12 flags kept", flags(), F_READ);
    wr(22'h80, 8'h11);
    chk("R12 no op", op_valid, 0);
  endtask

  task automatic t_bypass();
    prefix(10'h0); wr(22'h555, 8'h20);
    chk("R8 enter bypass", flags(), F_BYP);
    wr(22'h0, 8'hA0); wr(22'h000777, 8'h3C);
    expect_op("R8 short program", 3'd1, 22'h000777, 8'h3C);
    wr(22'h55, 8'h98);
    chk("R8 query ignored", flags(), F_BYP);
    wr(22'h0, 8'hF0);
    chk("R4 bypass kept", flags(), F_BYP);
    wr(22'h0, 8'h90); wr(22'h0, 8'h00);
    chk("R8 leave bypass", flags(), F_READ);
  endtask

  task automatic t_secure();
    prefix(10'h0); wr(22'h555, 8'h88);
    chk("R9 enter secure", flags(), F_SEC | F_READ);
    prefix(10'h0); wr(22'h555, 8'h90); wr(22'h0, 8'h00);
    chk("R9 exit secure", flags(), F_READ);
  endtask

  task automatic t_chip();
    prefix(10'h0); wr(22'h555, 8'h80); prefix(10'h0); wr(22'h000555, 8'h10);
    expect_op("R7 chip erase", 3'd2, 22'h000555, 8'h10);
    busy = 1'b1;
    wr(22'h0, 8'hB0);
    chk("R10 no suspend after chip", op_valid, 0);
    chk("R10 flags after chip", flags(), F_READ);
    busy = 1'b0;
  endtask

  task automatic t_sector();
    prefix(10'h0); wr(22'h555, 8'h80); prefix(10'h0); wr(22'h2A0000, 8'h30);
    expect_op("R7 sector erase", 3'd3, 22'h2A0000, 8'h30);
    chk("R7 sector number", sector, 6'h2A);
    busy = 1'b1;
    prefix(10'h0); wr(22'h0, 8'hA0); wr(22'h10, 8'h11);
    chk("R10 busy ignores", op_valid, 0);
    wr(22'h0, 8'hB0);
    expect_op("R10 suspend", 3'd4, 22'h0, 8'hB0);
    chk("R10 suspend flags", flags(), F_SUSP);
    busy = 1'b0;
    prefix(10'h0); wr(22'h0, 8'hA0); wr(22'h000099, 8'h66);
    expect_op("R11 program while suspended", 3'd1, 22'h000099, 8'h66);
    prefix(10'h0); wr(22'h555, 8'h80); prefix(10'h0); wr(22'h0, 8'h10);
    chk("R11 erase refused", op_valid, 0);
    wr(22'h0, 8'hF0);
    chk("R4 suspend kept", flags(), F_SUSP);
    wr(22'h55, 8'h98);
    chk("R6 no query in suspend", flags(), F_SUSP);
    wr(22'h0, 8'h30);
    expect_op("R11 resume", 3'd5, 22'h0, 8'h30);
    chk("R11 resume flags", flags(), F_READ);
    wr(22'h0, 8'h30);
    chk("R11 stray resume", op_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_reset_cmd();
    t_asel_cfi();
    t_unknown();
    t_bypass();
    t_secure();
    t_chip();
    t_sector();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule